// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block moves one byte at a time to and from an external device over three wires. It drives a shift clock of its own, drives the serial output line, and samples the serial input line. A frame starts when a byte is loaded with a one-cycle start strobe. The block then sends the byte least significant bit first while it gathers eight incoming bits. When the frame ends, the block shows the received byte and pulses a done flag for one cycle.

The shift clock runs only during a frame and idles high otherwise. Each bit takes six system clocks: the clock is low for three cycles and high for three. The output changes one system clock after each rising edge of the shift clock, which gives the receiver five system clocks of setup. The input is captured on the same system clock edge that raises the shift clock, so the far end needs no hold time. The reset is synchronous and ends any frame at once.

Top module: `shift_serial_port`

## Requirements
- R1: After reset, `serClk` and `serOut` are 1, `busy` and `rxDone` are 0, and `rxByte` is 0x00.
- R2: A `startStb` sampled high while `busy` is 0 loads `txByte`. Call that rising clock edge E0. From E0 on, `busy` is 1 and `serOut` carries bit 0 of the loaded byte.
- R3: During a frame, `serClk` goes low at edges E(2+6k) and high at edges E(5+6k), for k = 0..7. It is low for three system clocks and high for three, which gives exactly eight rising edges per frame. Outside a frame it stays high.
- R4: Bit k of the loaded byte is on `serOut` from edge E(6k) until edge E(6k+6). It therefore changes one system clock after each rising edge of the shift clock and is set up five system clocks before the next one.
- R5: The value of `serIn` at edge E(5+6k) becomes bit k of the received byte (bit 0 is the first bit received). `serIn` at any other edge has no effect.
- R6: At edge E48, one clock after the eighth rising edge, `busy` falls. At the same edge `rxByte` takes the assembled byte and `rxDone` is 1 for exactly one cycle. `rxByte` then holds that value until the next frame ends.
- R7: A `startStb` that arrives while `busy` is 1 is ignored: the frame in progress and its output bits are unchanged.
- R8: After E48, `serOut` returns to 1 and stays there while idle.
- R9: A synchronous reset during a frame ends it at once. On the next clock the port is back in the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startStb | input | 1 | Load-and-start strobe |
| txByte | input | 8 | Byte to send, taken on an accepted start |
| busy | output | 1 | A frame is in progress |
| rxByte | output | 8 | Last received byte |
| rxDone | output | 1 | One-cycle pulse when a frame completes |
| serClk | output | 1 | Shift clock, idles high |
| serOut | output | 1 | Serial data out, bit 0 first |
| serIn | input | 1 | Serial data in |

## Verification
The bench drives each input bit only during the single system clock just before its rising edge, and drives the inverted value in every other cycle. A design that sampled one cycle early or late would therefore build the complemented byte. The output line is checked cycle by cycle against a model of the six-clock bit cell, which catches a clock phase that is off by one or an output that changes on the rising edge instead of after it. A second start issued halfway through a frame would corrupt the rest of the bits if it were accepted. A reset applied mid-frame must bring back the idle clock and clear `rxByte`; a design that only stopped the counters would leave stale data behind.

// File: rtl/shift_serial_pkg.sv
package shift_serial_pkg;
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } strobeT;
endpackage

// File: rtl/shift_serial_ctrl.sv
module shift_serial_ctrl
  import shift_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF   = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   startStb,
  output logic   busy,
  output logic   serClk,
  output strobeT stb
);
  localparam int PERIOD = 2 * HALF;
  localparam int PW     = $clog2(PERIOD);
  localparam int KW     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PW-1:0] P_LAST  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] P_SAMP  = PW'(PERIOD - 2);
  localparam logic [PW-1:0] P_LOW0  = PW'(HALF - 1);
  localparam logic [KW-1:0] K_LAST  = KW'(DATA_W - 1);

  logic [PW-1:0] phase;
  logic [KW-1:0] bitIdx;
  logic          active;

  always_comb begin
    stb.load   = startStb && !active;
    stb.sample = active && (phase == P_SAMP);
    stb.shift  = active && (phase == P_LAST) && (bitIdx != K_LAST);
    stb.finish = active && (phase == P_LAST) && (bitIdx == K_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (stb.load) begin
      active <= 1'b1;
      phase  <= '0;
      bitIdx <= '0;
    end else if (active) begin
      if (phase == P_LAST) begin
        phase  <= '0;
        bitIdx <= bitIdx + 1'b1;
        if (stb.finish) active <= 1'b0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign busy   = active;
  assign serClk = !(active && (phase >= P_LOW0) && (phase < P_SAMP + 1'b1));

  // R3
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> serClk);
  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst) stb.finish |=> !busy);
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst) (busy && startStb && !stb.finish) |=> busy);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({stb.load, stb.sample, stb.shift, stb.finish}));
endmodule

// File: rtl/shift_serial_dp.sv
module shift_serial_dp
  import shift_serial_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] txByte,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
      rxByte  <= '0;
      rxDone  <= 1'b0;
      serOut  <= 1'b1;
    end else begin
      rxDone <= 1'b0;
      if (stb.load) begin
        txShift <= txByte;
        serOut  <= txByte[0];
      end
      if (stb.shift) begin
        txShift <= txShift >> 1;
        serOut  <= txShift[1];
      end
      if (stb.sample) rxShift <= {serIn, rxShift[DATA_W-1:1]};
      if (stb.finish) begin
        rxByte <= rxShift;
        rxDone <= 1'b1;
        serOut <= 1'b1;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) rxDone |=> !rxDone);
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) stb.sample |=> $stable(serOut));
  // R6
  rx_keep_chk: assert property (@(posedge clk) disable iff (rst) !stb.finish |=> $stable(rxByte));
endmodule

// File: rtl/shift_serial_port.sv
module shift_serial_port
  import shift_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startStb,
  input  logic [DATA_W-1:0] txByte,
  output logic              busy,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxDone,
  output logic              serClk,
  output logic              serOut,
  input  logic              serIn
);
  strobeT stb;

  shift_serial_ctrl #(.DATA_W(DATA_W), .HALF(HALF)) u_ctrl (
    .clk(clk), .rst(rst), .startStb(startStb),
    .busy(busy), .serClk(serClk), .stb(stb)
  );

  shift_serial_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .txByte(txByte), .serIn(serIn),
    .serOut(serOut), .rxByte(rxByte), .rxDone(rxDone)
  );

  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (rst) (startStb && !busy) |=> busy);
endmodule

// File: tb/tb_shift_serial_port.sv
module tb_shift_serial_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startStb = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       serIn = 1'b1;
  logic       busy, rxDone, serClk, serOut;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shift_serial_port dut (
    .clk(clk), .rst(rst), .startStb(startStb), .txByte(txByte),
    .busy(busy), .rxByte(rxByte), .rxDone(rxDone),
    .serClk(serClk), .serOut(serOut), .serIn(serIn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expClk(input int n);
    return !(n < 48 && (n % 6) >= 2 && (n % 6) <= 4);
  endfunction

  function automatic logic expOut(input logic [7:0] tx, input int n);
    return (n < 48) ? tx[n / 6] : 1'b1;
  endfunction

  function automatic logic expIn(input logic [7:0] rx, input int n);
    int k = n / 6;
    if (n >= 48) return 1'b0;
    return ((n % 6) == 4) ? rx[k] : ~rx[k];
  endfunction

  task automatic edgeWait();
    @(posedge clk);
    #2;
  endtask

  task automatic checkIdle(input string req);
    check(req, {7'd0, busy}, 8'd0);
    check(req, {7'd0, serClk}, 8'd1);
    check(req, {7'd0, serOut}, 8'd1);
    check(req, {7'd0, rxDone}, 8'd0);
  endtask

  // Runs a frame; abortAt >= 0 applies reset after that edge instead of finishing.
  task automatic runFrame(input logic [7:0] tx, input logic [7:0] rx,
                          input bit midStart, input int abortAt);
    txByte   = tx;
    startStb = 1'b1;
    edgeWait();
    startStb = 1'b0;
    txByte   = ~tx;
    for (int n = 0; n <= 49; n++) begin
      if (n > 0) edgeWait();
      if (n == 0) check("R2 busy", {7'd0, busy}, 8'd1);
      if (n < 49) begin
        check("R3 serClk", {7'd0, serClk}, {7'd0, expClk(n)});
        check(n < 48 ? "R4 serOut" : "R8 serOut", {7'd0, serOut}, {7'd0, expOut(tx, n)});
        check("R6 busy", {7'd0, busy}, {7'd0, (n < 48)});
        check("R6 rxDone", {7'd0, rxDone}, {7'd0, (n == 48)});
      end
      if (n == 48) check("R5 rxByte", rxByte, rx);
      if (n == 49) checkIdle("R6 idle after frame");
      serIn = expIn(rx, n);
      if (midStart) startStb = (n == 20);
      if (n == 20 && midStart) txByte = 8'h3C;
      if (n == abortAt) begin
        rst = 1'b1;
        edgeWait();
        rst = 1'b0;
        checkIdle("R9 reset mid-frame");
        check("R9 rxByte", rxByte, 8'h00);
        return;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    edgeWait();
    edgeWait();
    rst = 1'b0;
    // R1 reset state
    checkIdle("R1 reset");
    check("R1 rxByte", rxByte, 8'h00);
    runFrame(8'hA5, 8'h5A, 1'b0, -1);
    check("R6 rxByte held", rxByte, 8'h5A);
    runFrame(8'h00, 8'hFF, 1'b0, -1);
    runFrame(8'hFF, 8'h00, 1'b0, -1);
    // R7 start ignored while busy
    runFrame(8'h81, 8'h7E, 1'b1, -1);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] t, r;
      t = 8'($urandom);
      r = 8'($urandom);
      runFrame(t, r, (i % 2) == 1, -1);
    end
    // R9 mid-frame reset
    runFrame(8'hC3, 8'h96, 1'b0, 20);
    runFrame(8'h1E, 8'hE1, 1'b0, -1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule